// File: doc/BRIEF.md
# Window Watchdog Supervisor with Reset Stretcher

This block watches a heartbeat signal from a processor and drives an active-low system reset. The watchdog period is measured in timebase ticks. It is split into a closed window at the start and an open window at the end. A falling heartbeat edge in the open window services the watchdog. A falling edge in the closed window is an early fault. If the whole period passes without an edge, that is a late fault. Either fault pulls the reset low.

The reset is also pulled low while an external power-good level is low. After every reset cause has cleared, a stretcher keeps the reset low until a programmed number of ticks has passed. While the reset is low, the watchdog timer is held at zero and heartbeat edges have no effect. Each early fault, late fault and accepted edge is reported as a one-cycle pulse, which later escalation logic can count.

Top module: `wwdg_supervisor`

## Requirements
- R1: `win_sel_i` selects the length of the closed window for a period of P ticks: 0 or 3 gives 0 ticks (the whole period is open), 1 gives floor(P/2) ticks, and 2 gives floor(P/4) ticks. The timer counts ticks from the last start and is compared against this length.
- R2: A heartbeat falling edge is a cycle in which `hb_i` is 0 and was 1 in the previous cycle. Such an edge, seen while the timer value is below the closed-window length, raises `early_o` and pulls `sys_rst_n_o` low.
- R3: If no edge arrives, `late_o` rises and `sys_rst_n_o` falls on the tick that completes P ticks since the timer started.
- R4: An edge seen at or after the closed-window length raises `good_o`, leaves the reset high, and restarts the timer from zero. The next late fault then comes P ticks later.
- R5: While `sys_rst_n_o` is low, the timer is held at zero. After the reset is released, the timer counts from zero, so a late fault comes exactly P ticks after the release.
- R6: Heartbeat edges during a cycle in which `sys_rst_n_o` is low produce no pulse. At most one of the three pulses is high in any cycle.
- R7: While `pwr_ok_i` is low, `sys_rst_n_o` is low. A power-good drop produces no fault pulse.
- R8: After every reset cause has cleared, `sys_rst_n_o` stays low until `hold_len_i` ticks have been counted with `pwr_ok_i` high. It goes high in the cycle after the tick that completes that count. With `hold_len_i` = 0, it goes high one cycle after the causes clear. A watchdog fault therefore holds the reset low for exactly one stretch.
- R9: A `period_i` of 0 disables the watchdog: it produces no pulses and no watchdog resets.
- R10: While `rst_n` is low, `sys_rst_n_o` is low and all pulses are low. The stretch count starts once `rst_n` and `pwr_ok_i` are both high.
- R11: Each pulse lasts one cycle. A pulse and the resulting fall of `sys_rst_n_o` appear at the clock edge that ends the cycle containing the edge or tick that caused them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Timebase tick, one cycle wide |
| hb_i | input | 1 | Heartbeat, already synchronized to `clk` |
| pwr_ok_i | input | 1 | Power-good level, 1 when good |
| period_i | input | PERIOD_W | Watchdog period in ticks; 0 disables |
| win_sel_i | input | 2 | Closed-window selection (see R1) |
| hold_len_i | input | HOLD_W | Reset stretch length in ticks |
| sys_rst_n_o | output | 1 | Active-low system reset |
| early_o | output | 1 | Pulse on an early fault |
| late_o | output | 1 | Pulse on a late fault |
| good_o | output | 1 | Pulse on an accepted heartbeat edge |

## Verification
Every result appears one clock after its cause. A heartbeat edge or tick seen in cycle c shows up as a pulse, and as a falling reset, in the state of cycle c+1. A release is visible in the cycle after the tick that completes the stretch. The bench drives its inputs at the falling clock edge and then advances a cycle-level model built from the requirements. At the next falling edge it compares all four outputs against that model, so every cycle of every run is checked at exactly the cycle the result is due. The runs sweep the heartbeat edge through every cycle of the period, for both periods and all three window modes, with stretch lengths of 0, 1 and 2 and with slow ticks. Further runs cover a disabled period and a power-good drop in mid-period.

// File: rtl/wwdg_pkg.sv
// Shared types for the window watchdog supervisor.
// Assumes: none; the package holds only type definitions.
package wwdg_pkg;

    // Closed-window selection. The encoding is visible on win_sel_i.
    typedef enum logic [1:0] {
        WIN_OPEN100     = 2'd0,
        WIN_OPEN50      = 2'd1,
        WIN_OPEN75      = 2'd2,
        WIN_OPEN100_ALT = 2'd3
    } win_mode_e;

    // Watchdog events produced in one cycle.
    typedef struct packed {
        logic early;
        logic late;
        logic good;
    } wd_evt_t;

endpackage

// File: rtl/wwdg_edge_det.sv
// Falling-edge detector for the heartbeat.
// Keeps a registered copy of the heartbeat and flags a cycle in which the
// input is low while the copy is high.
// Assumes: hb_i is already synchronous to clk. The copy resets high, so a
// low level out of reset counts as an edge; the reset is low at that time,
// so such an edge has no effect.
module wwdg_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic hb_i,
    output logic fall_o
);

    logic hb_q;

    // Keep the heartbeat value from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hb_q <= 1'b1;
        end else begin
            hb_q <= hb_i;
        end
    end

    // Flag a high-to-low change between consecutive cycles.
    always_comb begin
        fall_o = hb_q & ~hb_i;
    end

endmodule

// File: rtl/wwdg_timer.sv
// Window watchdog timer.
// Counts ticks since the last start, classifies each heartbeat edge as
// early or good against the closed-window length, and flags a late fault
// on the tick that completes the period.
// Assumes: armed_i is high only while the system reset is released. The
// period and window mode change only while armed_i is low.
module wwdg_timer #(
    parameter int PERIOD_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_i,
    input  logic                  fall_i,
    input  logic                  armed_i,
    input  logic [PERIOD_W-1:0]   period_i,
    input  wwdg_pkg::win_mode_e   mode_i,
    output wwdg_pkg::wd_evt_t     evt_o
);
    import wwdg_pkg::*;

    localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

    logic [PERIOD_W-1:0] cnt;
    logic [PERIOD_W-1:0] closed_len;
    logic                run;
    logic                in_closed;
    logic                at_end;

    // Work out the closed-window length from the period and the mode.
    always_comb begin
        unique case (mode_i)
            WIN_OPEN50: closed_len = period_i >> 1;
            WIN_OPEN75: closed_len = period_i >> 2;
            default:    closed_len = '0;
        endcase
    end

    // Derive the conditions for the current cycle.
    always_comb begin
        run       = armed_i && (period_i != '0);
        in_closed = (cnt < closed_len);
        at_end    = (cnt >= (period_i - ONE));
    end

    // Classify the events for this cycle.
    always_comb begin
        evt_o.early = run & fall_i & in_closed;
        evt_o.good  = run & fall_i & ~in_closed;
        evt_o.late  = run & ~fall_i & tick_i & at_end;
    end

    // Tick counter: hold it at zero while not running and clear it on an edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || fall_i) begin
            cnt <= '0;
        end else if (tick_i) begin
            cnt <= at_end ? '0 : (cnt + ONE);
        end
    end

endmodule

// File: rtl/wwdg_stretch.sv
// Reset stretcher.
// Pulls the reset low on a fault or while power is not good. Once both
// causes have cleared, it holds the reset low until hold_len_i ticks have
// been counted, and then releases it.
// Assumes: fault_i is a single-cycle strobe; the reset is low out of reset.
module wwdg_stretch #(
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              pwr_ok_i,
    input  logic              fault_i,
    input  logic [HOLD_W-1:0] hold_len_i,
    output logic              rst_n_o
);

    localparam int CW = HOLD_W + 1;

    logic [HOLD_W-1:0] held;
    logic              done;

    // Decide whether this cycle completes the stretch.
    always_comb begin
        done = (hold_len_i == '0) ||
               (tick_i && ((CW'(held) + CW'(1)) >= CW'(hold_len_i)));
    end

    // Track the reset level and the number of ticks counted so far.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_n_o <= 1'b0;
            held    <= '0;
        end else if (!pwr_ok_i || fault_i) begin
            rst_n_o <= 1'b0;
            held    <= '0;
        end else if (!rst_n_o) begin
            if (done) begin
                rst_n_o <= 1'b1;
                held    <= '0;
            end else if (tick_i) begin
                held    <= held + HOLD_W'(1);
            end
        end
    end

endmodule

// File: rtl/wwdg_supervisor.sv
// Window watchdog supervisor: top level.
// Ties the heartbeat edge detector, the window timer and the reset
// stretcher together and registers the one-cycle event pulses, so that
// each pulse lines up with the fall of the reset it causes.
// Assumes: tick_i and hb_i are synchronous to clk.
module wwdg_supervisor #(
    parameter int PERIOD_W = 16,
    parameter int HOLD_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic                hb_i,
    input  logic                pwr_ok_i,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic [1:0]          win_sel_i,
    input  logic [HOLD_W-1:0]   hold_len_i,
    output logic                sys_rst_n_o,
    output logic                early_o,
    output logic                late_o,
    output logic                good_o
);
    import wwdg_pkg::*;

    logic      fall;
    logic      fault;
    wd_evt_t   evt;
    win_mode_e mode;

    // Map the window selection onto its mode.
    always_comb begin
        mode  = win_mode_e'(win_sel_i);
        fault = evt.early | evt.late;
    end

    wwdg_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .hb_i   (hb_i),
        .fall_o (fall)
    );

    wwdg_timer #(.PERIOD_W(PERIOD_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .fall_i   (fall),
        .armed_i  (sys_rst_n_o),
        .period_i (period_i),
        .mode_i   (mode),
        .evt_o    (evt)
    );

    wwdg_stretch #(.HOLD_W(HOLD_W)) u_stretch (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .pwr_ok_i   (pwr_ok_i),
        .fault_i    (fault),
        .hold_len_i (hold_len_i),
        .rst_n_o    (sys_rst_n_o)
    );

    // Register the event pulses so that they line up with the reset edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            early_o <= 1'b0;
            late_o  <= 1'b0;
            good_o  <= 1'b0;
        end else begin
            early_o <= evt.early;
            late_o  <= evt.late;
            good_o  <= evt.good;
        end
    end

endmodule

// File: rtl/wwdg_supervisor_chk.sv
// Assertion checker for wwdg_supervisor, attached with the bind below.
// Assumes: checks are disabled while the block reset is low.
module wwdg_supervisor_chk #(
    parameter int PERIOD_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                pwr_ok_i,
    input logic [PERIOD_W-1:0] period_i,
    input logic                sys_rst_n_o,
    input logic                early_o,
    input logic                late_o,
    input logic                good_o
);

    a_r2_early_drops_reset: assert property (@(posedge clk) disable iff (!rst_n)
        early_o |-> !sys_rst_n_o);

    a_r3_late_drops_reset: assert property (@(posedge clk) disable iff (!rst_n)
        late_o |-> !sys_rst_n_o);

    a_r4_good_keeps_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (good_o && $past(pwr_ok_i)) |-> sys_rst_n_o);

    a_r6_no_pulse_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_rst_n_o |=> !(early_o || good_o || late_o));

    a_r6_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({early_o, late_o, good_o}));

    a_r7_power_low_resets: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok_i |=> !sys_rst_n_o);

    a_r8_release_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n_o) |-> $past(pwr_ok_i));

    a_r9_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (period_i == '0) |=> !(early_o || good_o || late_o));

    a_r11_early_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        early_o |=> !early_o);

    a_r11_late_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        late_o |=> !late_o);

endmodule

bind wwdg_supervisor wwdg_supervisor_chk #(.PERIOD_W(PERIOD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_ok_i    (pwr_ok_i),
    .period_i    (period_i),
    .sys_rst_n_o (sys_rst_n_o),
    .early_o     (early_o),
    .late_o      (late_o),
    .good_o      (good_o)
);

// File: tb/wwdg_supervisor_tb_top.sv
// Bench for wwdg_supervisor: drives inputs at the falling clock edge and
// compares every output in every cycle against a cycle model built from
// the requirements.
module wwdg_supervisor_tb_top;

    localparam int PW = 16;
    localparam int HW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_i = 1'b0;
    logic          hb_i = 1'b1;
    logic          pwr_ok_i = 1'b0;
    logic [PW-1:0] period_i = '0;
    logic [1:0]    win_sel_i = 2'd0;
    logic [HW-1:0] hold_len_i = '0;
    logic          sys_rst_n_o;
    logic          early_o;
    logic          late_o;
    logic          good_o;

    int n_chk = 0;
    int n_bad = 0;

    // Model state
    int   cfg_per = 0;
    int   cfg_sel = 0;
    int   cfg_len = 0;
    int   tdiv = 1;
    int   gcnt = 0;
    logic m_rst = 1'b0;
    logic m_hbq = 1'b1;
    int   m_cnt = 0;
    int   m_hold = 0;

    always #2 clk = ~clk;

    wwdg_supervisor #(.PERIOD_W(PW), .HOLD_W(HW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .hb_i        (hb_i),
        .pwr_ok_i    (pwr_ok_i),
        .period_i    (period_i),
        .win_sel_i   (win_sel_i),
        .hold_len_i  (hold_len_i),
        .sys_rst_n_o (sys_rst_n_o),
        .early_o     (early_o),
        .late_o      (late_o),
        .good_o      (good_o)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // R1: closed-window length in ticks for the selected mode
    function automatic int closed_of(input int per, input int sel);
        if (sel == 1) return per / 2;
        if (sel == 2) return per / 4;
        return 0;
    endfunction

    // One cycle: drive the inputs, advance the model, check at the next falling edge.
    task automatic step(input logic hbv, input logic pv);
        logic tk, fall, run, e, g, l;
        string ptag;
        string rtag;
        tk = ((gcnt % tdiv) == 0);
        gcnt++;
        hb_i = hbv;
        pwr_ok_i = pv;
        tick_i = tk;
        fall = m_hbq & ~hbv;
        run  = m_rst && (cfg_per != 0);
        e = run && fall && (m_cnt < closed_of(cfg_per, cfg_sel));
        g = run && fall && !(m_cnt < closed_of(cfg_per, cfg_sel));
        l = run && !fall && tk && (m_cnt >= cfg_per - 1);
        // R5: timer held at zero while reset is low; R4: cleared by an edge
        if (!run || fall) m_cnt = 0;
        else if (tk) m_cnt = (m_cnt >= cfg_per - 1) ? 0 : m_cnt + 1;
        ptag = (cfg_per == 0) ? "R9" : (!m_rst ? "R6" : "R11");
        rtag = e ? "R2" : (l ? "R3" : (!pv ? "R7" : "R8"));
        // R8: stretch after all causes clear
        if (!pv || e || l) begin
            m_rst = 1'b0;
            m_hold = 0;
        end else if (!m_rst) begin
            if (cfg_len == 0 || (tk && m_hold + 1 >= cfg_len)) begin
                m_rst = 1'b1;
                m_hold = 0;
            end else if (tk) begin
                m_hold++;
            end
        end
        m_hbq = hbv;
        @(negedge clk);
        chk(sys_rst_n_o, m_rst, rtag);
        chk(early_o, e, {ptag, " R2 early"});
        chk(late_o, l, {ptag, " R3 late"});
        chk(good_o, g, {ptag, " R4 good"});
    endtask

    // Configure while power is low, wait for release, then put one edge at cycle k.
    task automatic run_case(input int per, input int sel, input int k, input int len, input int div);
        int guard;
        cfg_per = per; cfg_sel = sel; cfg_len = len; tdiv = div;
        period_i = PW'(per);
        win_sel_i = 2'(sel);
        hold_len_i = HW'(len);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        guard = 0;
        // R6: heartbeat toggles while the reset is held
        while (!m_rst && guard < 400) begin
            step(((guard % 2) == 1) ? 1'b0 : 1'b1, 1'b1);
            guard++;
        end
        if (!m_rst) step(1'b1, 1'b1);
        for (int i = 0; i < k + 3 * (per + len + 2) * div + 6; i++) begin
            step((i == k) ? 1'b0 : 1'b1, 1'b1);
        end
    endtask

    initial begin
        // R10: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(sys_rst_n_o, 1'b0, "R10 reset level");
        chk(early_o | late_o | good_o, 1'b0, "R10 pulses in reset");
        rst_n = 1'b1;
        m_rst = 1'b0; m_hbq = 1'b1; m_cnt = 0; m_hold = 0;
        cfg_per = 4; cfg_len = 2;
        period_i = PW'(4); hold_len_i = HW'(2);
        // R10: stretch starts once power is good
        step(1'b1, 1'b1);
        chk(sys_rst_n_o, 1'b0, "R10 still held after one cycle");

        // R1 R2 R3 R4 R5 R8: sweep the edge through every cycle of the period
        for (int per = 4; per <= 8; per += 4)
            for (int sel = 0; sel < 3; sel++)
                for (int k = 0; k <= per; k++)
                    run_case(per, sel, k, k % 3, 1);

        // R1 R3: slow ticks, edge swept across the period
        for (int k = 0; k <= 13; k++) run_case(4, 1, k, 2, 3);
        for (int k = 0; k <= 9; k += 3) run_case(8, 2, k, 1, 2);

        // R9: zero period disables the watchdog
        run_case(0, 1, 3, 1, 1);
        for (int i = 0; i < 30; i++) step(((i % 3) == 0) ? 1'b0 : 1'b1, 1'b1);

        // R7: power drop in mid-period, no fault pulse, then a fresh stretch
        run_case(8, 0, 20, 2, 1);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
        for (int i = 0; i < 30; i++) step(1'b1, 1'b1);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog on the run itself
    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog expired, run did not finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule